// File: doc/BRIEF.md
# YCbCr 4:2:2 Line Unpacker

This block sits behind the character decoders of a digital video sink that is carrying YCbCr 4:2:2 video. Each clock it receives one decoded 8-bit character on each of three channels. Two consecutive characters together describe a pair of pixels with 12-bit components. The block rebuilds the components and emits one full pixel per clock, with Y, Cb and Cr all present. Both pixels of a pair carry the same chroma.

An active run is a stretch of cycles with `vld_i` high. The first characters of each run are a guard band and are discarded. The phase of each pair restarts with every run. An optional stage maps studio-level values (black at 16, white at 239 on an 8-bit scale) onto the full 12-bit range. The sync strobes travel through the same fixed latency as the pixels, so each pixel leaves beside the hsync and vsync that came in with its character.

Top module: `ycc422_unpack`

## Requirements
- R1: While `rst_ni` is low and after its release, `vld_o`, `hs_o` and `vs_o` are 0 and `y_o`, `cb_o` and `cr_o` are 0 until the first pixel is emitted.
- R2: A character gives luma = {ch0_i, ch1_i[3:0]} and chroma = {ch2_i, ch1_i[7:4]}, each 12 bits.
- R3: The first GUARD_LEN (default 2) characters of every active run produce no output pixel, so a run of GUARD_LEN+2N characters yields exactly 2N pixels.
- R4: After the guard band, characters alternate between first-of-pair (luma Y0 with Cb) and second-of-pair (luma Y1 with Cr). The alternation starts from first-of-pair at every new run.
- R5: Both pixels of a pair leave with the Cb of the first character and the Cr of the second.
- R6: Each pixel appears on the outputs with `vld_o` high in the second cycle after the cycle in which its character was presented. The two pixels of a pair occupy consecutive cycles.
- R7: `hs_o` and `vs_o` equal `hs_i` and `vs_i` delayed by exactly two cycles.
- R8: With `expand_i` high when a character is presented, each of its components v becomes 0 if v < 256. Otherwise it becomes min(4095, ((v-256)*1171 + 512) >> 10). This maps 256 to 0 and 3824 to 4080.
- R9: With `expand_i` low, components pass through unchanged.
- R10: A first-of-pair character that is not followed by its partner before the run ends produces no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Character belongs to an active run |
| ch0_i | input | 8 | Channel 0 character: luma upper bits |
| ch1_i | input | 8 | Channel 1 character: chroma low nibble (7:4), luma low nibble (3:0) |
| ch2_i | input | 8 | Channel 2 character: chroma upper bits |
| hs_i | input | 1 | Horizontal sync beside the character |
| vs_i | input | 1 | Vertical sync beside the character |
| expand_i | input | 1 | Expand studio range to full range |
| vld_o | output | 1 | Output pixel valid |
| y_o | output | 12 | Luma |
| cb_o | output | 12 | Blue-difference chroma |
| cr_o | output | 12 | Red-difference chroma |
| hs_o | output | 1 | Delayed horizontal sync |
| vs_o | output | 1 | Delayed vertical sync |

## Verification
The assertions rely on a few properties of the input. `vld_i` stays high without a gap for a whole active run, and at least one low cycle separates two runs. GUARD_LEN is at least one. `expand_i` holds its value across the two characters of a pair. The stimulus drives every run as one contiguous block of characters with at least one idle cycle between runs. It changes `expand_i` only between pairs, and it deliberately ends some runs with an unpaired first character.

// File: rtl/ycc_pkg.sv
package ycc_pkg;
  localparam int CH_W   = 8;
  localparam int COMP_W = 12;
  localparam int LO_W   = COMP_W - CH_W;
  typedef logic [COMP_W-1:0] comp_t;
endpackage

// File: rtl/ycc_line_track.sv
module ycc_line_track #(
  parameter int GUARD_LEN = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vld_i,
  output logic pix_o,
  output logic odd_o
);
  localparam int CW = $clog2(GUARD_LEN + 2);

  logic [CW-1:0] gcnt_q;
  logic          odd_q;
  logic          in_guard;

  assign in_guard = gcnt_q < CW'(GUARD_LEN);
  assign pix_o    = vld_i & ~in_guard;
  assign odd_o    = odd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gcnt_q <= '0;
      odd_q  <= 1'b0;
    end else if (!vld_i) begin
      gcnt_q <= '0;
      odd_q  <= 1'b0;
    end else if (in_guard) begin
      gcnt_q <= gcnt_q + CW'(1);
    end else begin
      odd_q  <= ~odd_q;
    end
  end

  // R4: a run always opens on the first-of-pair phase
  a_r4_phase_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> !odd_o);
endmodule

// File: rtl/ycc_range.sv
module ycc_range #(
  parameter int W    = 12,
  parameter int FRAC = 10
) (
  input  logic [W-1:0] in_i,
  input  logic         en_i,
  output logic [W-1:0] out_o
);
  localparam int BLACK    = 16 << (W - 8);
  localparam int WHITE_IN = 239 << (W - 8);
  localparam int WHITE_FS = 255 << (W - 8);
  localparam int K        = ((255 << FRAC) + 111) / 223;
  localparam int HALF     = 1 << (FRAC - 1);
  localparam int MAXV     = (1 << W) - 1;
  localparam int PW       = W + FRAC + 2;

  logic [PW-1:0] prod;
  logic [PW-1:0] shifted;

  always_comb begin
    prod    = PW'(in_i - W'(BLACK)) * PW'(K) + PW'(HALF);
    shifted = prod >> FRAC;
    if (!en_i)                   out_o = in_i;
    else if (in_i < W'(BLACK))   out_o = '0;
    else if (shifted > PW'(MAXV)) out_o = W'(MAXV);
    else                         out_o = shifted[W-1:0];
  end

  always_comb begin
    if (en_i && in_i == W'(BLACK))
      a_r8_black: assert (out_o == '0);
    if (en_i && in_i == W'(WHITE_IN))
      a_r8_white: assert ((out_o >= W'(WHITE_FS - 1)) && (out_o <= W'(WHITE_FS + 1)));
  end
endmodule

// File: rtl/ycc_pair.sv
module ycc_pair
  import ycc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  pix_i,
  input  logic  odd_i,
  input  comp_t y_i,
  input  comp_t c_i,
  output logic  vld_o,
  output logic  sec_o,
  output comp_t y_o,
  output comp_t cb_o,
  output comp_t cr_o
);
  comp_t y0_q, cb_q, y1_q;
  logic  pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y0_q   <= '0;
      cb_q   <= '0;
      y1_q   <= '0;
      pend_q <= 1'b0;
      vld_o  <= 1'b0;
      sec_o  <= 1'b0;
      y_o    <= '0;
      cb_o   <= '0;
      cr_o   <= '0;
    end else begin
      if (pix_i && !odd_i) begin
        y0_q <= y_i;
        cb_q <= c_i;
      end
      if (pix_i && odd_i) begin
        // pair complete: first pixel now, second next cycle
        vld_o  <= 1'b1;
        sec_o  <= 1'b0;
        y_o    <= y0_q;
        cb_o   <= cb_q;
        cr_o   <= c_i;
        y1_q   <= y_i;
        pend_q <= 1'b1;
      end else if (pend_q) begin
        vld_o  <= 1'b1;
        sec_o  <= 1'b1;
        y_o    <= y1_q;
        pend_q <= 1'b0;
      end else begin
        vld_o  <= 1'b0;
        sec_o  <= 1'b0;
      end
    end
  end

  a_r5_chroma_shared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_o |-> ($past(vld_o) && !$past(sec_o) && $stable(cb_o) && $stable(cr_o)));

  a_r6_pair_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && !sec_o) |=> (vld_o && sec_o));
endmodule

// File: rtl/ycc422_unpack.sv
module ycc422_unpack
  import ycc_pkg::*;
#(
  parameter int GUARD_LEN = 2,
  parameter int FRAC      = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [CH_W-1:0]   ch0_i,
  input  logic [CH_W-1:0]   ch1_i,
  input  logic [CH_W-1:0]   ch2_i,
  input  logic              hs_i,
  input  logic              vs_i,
  input  logic              expand_i,
  output logic              vld_o,
  output logic [COMP_W-1:0] y_o,
  output logic [COMP_W-1:0] cb_o,
  output logic [COMP_W-1:0] cr_o,
  output logic              hs_o,
  output logic              vs_o
);
  localparam int LAT = 2;

  logic  pix, odd, sec;
  comp_t raw [2];
  comp_t cooked [2];

  assign raw[0] = {ch0_i, ch1_i[LO_W-1:0]};
  assign raw[1] = {ch2_i, ch1_i[CH_W-1 -: LO_W]};

  ycc_line_track #(.GUARD_LEN(GUARD_LEN)) u_track (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (vld_i),
    .pix_o (pix),
    .odd_o (odd)
  );

  for (genvar g = 0; g < 2; g++) begin : g_rng
    ycc_range #(.W(COMP_W), .FRAC(FRAC)) u_rng (
      .in_i (raw[g]),
      .en_i (expand_i),
      .out_o(cooked[g])
    );
  end

  ycc_pair u_pair (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pix_i (pix),
    .odd_i (odd),
    .y_i   (cooked[0]),
    .c_i   (cooked[1]),
    .vld_o (vld_o),
    .sec_o (sec),
    .y_o   (y_o),
    .cb_o  (cb_o),
    .cr_o  (cr_o)
  );

  logic [LAT-1:0] hs_sr, vs_sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_sr <= '0;
      vs_sr <= '0;
    end else begin
      hs_sr <= {hs_sr[LAT-2:0], hs_i};
      vs_sr <= {vs_sr[LAT-2:0], vs_i};
    end
  end

  assign hs_o = hs_sr[LAT-1];
  assign vs_o = vs_sr[LAT-1];

  // checker-only warm-up count so $past never reaches before reset release
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_q <= '0;
    else if (warm_q != 2'd2)  warm_q <= warm_q + 2'd1;
  end

  a_r7_sync_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2) |-> (hs_o == $past(hs_i, 2) && vs_o == $past(vs_i, 2)));

  a_r3_guard_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vld_i) |=> !vld_o ##1 !vld_o);

  a_r6_sec_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec |-> $past(vld_o));
endmodule

// File: tb/ycc422_unpack_bench.sv
module ycc422_unpack_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        vld_i = 1'b0;
  logic [7:0]  ch0_i = '0, ch1_i = '0, ch2_i = '0;
  logic        hs_i = 1'b0, vs_i = 1'b0, expand_i = 1'b0;
  logic        vld_o, hs_o, vs_o;
  logic [11:0] y_o, cb_o, cr_o;

  always #4 clk_i = ~clk_i;

  ycc422_unpack u_ycc422_unpack (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(vld_i),
    .ch0_i(ch0_i), .ch1_i(ch1_i), .ch2_i(ch2_i),
    .hs_i(hs_i), .vs_i(vs_i), .expand_i(expand_i),
    .vld_o(vld_o), .y_o(y_o), .cb_o(cb_o), .cr_o(cr_o),
    .hs_o(hs_o), .vs_o(vs_o)
  );

  // {expand, y0, y1, cb, cr}
  localparam logic [48:0] VEC [8] = '{
    {1'b0, 12'h123, 12'h456, 12'h789, 12'hABC},
    {1'b0, 12'hFFF, 12'h000, 12'h800, 12'h7FF},
    {1'b1, 12'h100, 12'hEF0, 12'h800, 12'hF00},
    {1'b1, 12'h0FF, 12'hFFF, 12'h0A5, 12'h5A0},
    {1'b0, 12'h001, 12'hFFE, 12'hF0F, 12'h0F0},
    {1'b1, 12'h800, 12'h400, 12'h200, 12'hC00},
    {1'b0, 12'hAAA, 12'h555, 12'h3C3, 12'hC3C},
    {1'b1, 12'hEF0, 12'h101, 12'h100, 12'hEF1}
  };

  int total = 0, bad = 0, k = 0, pcnt = 0;
  bit done = 1'b0;
  logic cur_hs = 1'b0, cur_vs = 1'b0;

  logic        e_vld [8];
  logic        e_hs [8], e_vs [8];
  logic [11:0] e_y [8], e_cb [8], e_cr [8];
  string       e_tag [8];

  int          b_g = 0;
  bit          b_ph = 1'b0;
  logic [11:0] b_y0 = '0, b_cb = '0;

  function automatic logic [11:0] xp(input logic [11:0] v);
    int r;
    if (v < 12'd256) return 12'd0;
    r = ((int'(v) - 256) * 1171 + 512) / 1024;
    if (r > 4095) r = 4095;
    return 12'(r);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (k=%0d)", tag, act, exp, k);
    end
  endtask

  always @(negedge clk_i) if (rst_ni && vld_o) pcnt++;

  task automatic check_slot();
    int i;
    i = k % 8;
    chk("R6 vld", int'(vld_o), int'(e_vld[i]));
    chk("R7 hs", int'(hs_o), int'(e_hs[i]));
    chk("R7 vs", int'(vs_o), int'(e_vs[i]));
    if (e_vld[i]) begin
      chk({e_tag[i], " y"}, int'(y_o), int'(e_y[i]));
      chk({e_tag[i], " R5 cb"}, int'(cb_o), int'(e_cb[i]));
      chk({e_tag[i], " R5 cr"}, int'(cr_o), int'(e_cr[i]));
    end
    e_vld[i] = 1'b0;
  endtask

  task automatic put(input int at, input logic [11:0] y, cb, cr, input string tag);
    e_vld[at % 8] = 1'b1;
    e_y[at % 8]   = y;
    e_cb[at % 8]  = cb;
    e_cr[at % 8]  = cr;
    e_tag[at % 8] = tag;
  endtask

  task automatic drive(input logic v, input logic [7:0] a, b, c, input logic ex);
    logic [11:0] yy, cc;
    @(negedge clk_i);
    check_slot();
    vld_i = v; ch0_i = a; ch1_i = b; ch2_i = c;
    hs_i = cur_hs; vs_i = cur_vs; expand_i = ex;
    e_hs[(k + 2) % 8] = cur_hs;
    e_vs[(k + 2) % 8] = cur_vs;
    if (!v) begin
      b_g = 0; b_ph = 1'b0;
    end else if (b_g < 2) begin
      b_g++;
    end else begin
      yy = {a, b[3:0]};
      cc = {c, b[7:4]};
      if (ex) begin yy = xp(yy); cc = xp(cc); end
      if (!b_ph) begin
        b_y0 = yy; b_cb = cc;
      end else begin
        put(k + 1, b_y0, b_cb, cc, ex ? "R8" : "R2/R9");
        put(k + 2, yy, b_cb, cc, ex ? "R8" : "R2/R9");
      end
      b_ph = ~b_ph;
    end
    k++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 8'h00, 8'h00, 8'h00, 1'b0);
  endtask

  task automatic guard();
    // guard characters look like real data; they must be dropped (R3)
    drive(1'b1, 8'hFF, 8'hFF, 8'hFF, 1'b0);
    drive(1'b1, 8'h5A, 8'hA5, 8'h3C, 1'b0);
  endtask

  task automatic send(input logic [11:0] y, c, input logic ex);
    drive(1'b1, y[11:4], {c[3:0], y[3:0]}, c[11:4], ex);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      e_vld[i] = 1'b0; e_hs[i] = 1'b0; e_vs[i] = 1'b0;
      e_y[i] = '0; e_cb[i] = '0; e_cr[i] = '0; e_tag[i] = "R1";
    end
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1 vld", int'(vld_o), 0);
    chk("R1 y", int'(y_o), 0);
    chk("R1 cb", int'(cb_o), 0);
    chk("R1 cr", int'(cr_o), 0);
    chk("R1 hs", int'(hs_o), 0);
    chk("R1 vs", int'(vs_o), 0);
    rst_ni = 1'b1;

    // table walk: one run of eight pairs (R2 R4 R5 R6 R8 R9)
    idle(2);
    pcnt = 0;
    guard();
    for (int i = 0; i < 8; i++) begin
      send(VEC[i][47:36], VEC[i][23:12], VEC[i][48]);
      send(VEC[i][35:24], VEC[i][11:0], VEC[i][48]);
    end
    idle(4);
    chk("R3 pixel count", pcnt, 16);

    // R10 and R4: unpaired trailing character, then a run after one idle cycle
    cur_hs = 1'b1;
    idle(2);
    cur_hs = 1'b0;
    pcnt = 0;
    guard();
    send(12'h321, 12'h111, 1'b0);
    send(12'h654, 12'h222, 1'b0);
    send(12'h987, 12'h333, 1'b0);
    idle(1);
    cur_vs = 1'b1;
    guard();
    send(12'hABC, 12'h444, 1'b1);
    cur_vs = 1'b0;
    send(12'hDEF, 12'h555, 1'b1);
    idle(4);
    chk("R10 pixel count", pcnt, 4);

    // R7: sync strobes toggling inside and outside runs
    pcnt = 0;
    for (int i = 0; i < 6; i++) begin
      cur_hs = i[0];
      cur_vs = i[1];
      idle(1);
    end
    guard();
    cur_hs = 1'b1;
    send(12'h0F0, 12'hF0F, 1'b0);
    cur_hs = 1'b0;
    send(12'hF0F, 12'h0F0, 1'b0);
    idle(4);
    chk("R3 guard-only count", pcnt, 2);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R6 watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule